// File: doc/BRIEF.md
# Monitor Mode Entry Controller

This block makes the boot-time choice between monitor mode and normal mode. The choice is made once, on the first clock after power-on reset is released. It samples three things: the two reset-vector bytes, the IRQ pin level, and whether the RST pin carries the high test voltage. The outcome is one of four entry conditions. That condition is held until the next power-on reset.

From the held condition the block drives several controls:
- the PLL enable and the fixed PLL multiplier;
- the bus clock source;
- a one-cycle extra reset request;
- the enable for the port-B entry checks;
- the watchdog disable.

The watchdog disable keeps following the live IRQ and RST levels for as long as the high-voltage entry lasts. All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

The IRQ level arrives as a 2-bit code: 00 = low, 01 = supply, 10 = high test voltage, 11 = treated as supply. The entry condition output uses this code: 0 = normal, 1 = high-voltage entry, 2 = blank vector at supply level, 3 = blank vector with PLL.

Top module: `mon_entry_ctrl`

## Requirements
- R1: The vector counts as blank only when both `vec_hi` and `vec_lo` equal 8'hFF. If just one byte is 8'hFF, the vector is not blank.
- R2: If IRQ code 10 is sampled, the block enters monitor mode with condition 1, whatever the vector holds. In that mode the PLL is off, `bus_clk_pll` is 0 (clock comes straight from the oscillator) and `portb_chk_en` is 1.
- R3: A blank vector with IRQ code 01 or 11 enters monitor mode with condition 2. The PLL is off and `portb_chk_en` is 0.
- R4: A blank vector with IRQ code 00 enters condition 3. `pll_en` = 1, `bus_clk_pll` = 1, `pll_mult` = 75 and `portb_chk_en` = 0.
- R5: A non-blank vector with IRQ code other than 10 gives normal mode. Every output is 0 and `entry_cond` = 0.
- R6: For conditions 2 and 3 only, `extra_rst` is high for exactly one cycle, the cycle right after the sampling edge, and never again before the next power-on reset.
- R7: In conditions 2 and 3, `cop_dis` stays 1 whatever IRQ and RST do later.
- R8: In condition 1, `cop_dis` is 1 exactly while IRQ code is 10 or `rst_hv` is 1.
- R9: The mode and condition stay latched until the next power-on reset. Input changes after sampling, including during the extra reset cycle, have no effect.
- R10: While `por_n` is low, and before sampling, every output is 0.
- R11: `pll_mult` reads 0 whenever `pll_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| vec_hi | input | 8 | Reset vector byte at the higher address |
| vec_lo | input | 8 | Reset vector byte at the lower address |
| irq_lvl | input | 2 | IRQ pin level code |
| rst_hv | input | 1 | RST pin at high test voltage |
| mon_mode | output | 1 | Monitor mode active |
| entry_cond | output | 2 | Latched entry condition |
| pll_en | output | 1 | PLL enable |
| pll_mult | output | 7 | PLL multiplier, 75 when enabled |
| bus_clk_pll | output | 1 | 1 = bus clock from PLL, 0 = from oscillator |
| extra_rst | output | 1 | One-cycle extra reset request |
| portb_chk_en | output | 1 | Port-B entry checks enforced |
| cop_dis | output | 1 | Watchdog disable |

## Verification
The bench covers four groups of corner cases:
- **Half-blank vectors.** A decoder that tests only one byte would wrongly enter monitor mode.
- **The 11 IRQ code.** A design that misreads this code would skip the supply-level entry or pick the PLL.
- **High-voltage entry with a blank vector.** A design that ranks the blank vector first would turn on the PLL and issue a spurious extra reset.
- **Inputs that change after entry.** This shows whether a design resamples during the extra reset cycle or lets the watchdog disable drift.

For the high-voltage case it also walks the IRQ-to-RST handover. A design that latched the watchdog disable, or looked at IRQ alone, would leave the watchdog off or turn it back on at the wrong moment.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;
  typedef enum logic [1:0] {
    ENTRY_NONE      = 2'd0,
    ENTRY_HV        = 2'd1,
    ENTRY_BLANK_SUP = 2'd2,
    ENTRY_BLANK_PLL = 2'd3
  } entry_e;

  localparam logic [1:0] IRQ_LOW = 2'b00;
  localparam logic [1:0] IRQ_TV  = 2'b10;
endpackage

// File: rtl/mon_entry_decode.sv
module mon_entry_decode
  import mon_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] vec_hi,
  input  logic [VEC_W-1:0] vec_lo,
  input  logic [1:0]       irq_lvl,
  output entry_e           cond
);
  localparam logic [VEC_W-1:0] ERASED = {VEC_W{1'b1}};

  logic blank;
  assign blank = (vec_hi == ERASED) && (vec_lo == ERASED);

  always_comb begin
    if (irq_lvl == IRQ_TV)       cond = ENTRY_HV;
    else if (!blank)             cond = ENTRY_NONE;
    else if (irq_lvl == IRQ_LOW) cond = ENTRY_BLANK_PLL;
    else                         cond = ENTRY_BLANK_SUP;
  end
endmodule

// File: rtl/mon_entry_latch.sv
module mon_entry_latch
  import mon_entry_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  entry_e cond_in,
  output entry_e cond_q,
  output logic   sampled,
  output logic   extra_rst
);
  logic blank_in;
  assign blank_in = (cond_in == ENTRY_BLANK_SUP) || (cond_in == ENTRY_BLANK_PLL);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cond_q    <= ENTRY_NONE;
      sampled   <= 1'b0;
      extra_rst <= 1'b0;
    end else if (!sampled) begin
      cond_q    <= cond_in;
      sampled   <= 1'b1;
      extra_rst <= blank_in;
    end else begin
      extra_rst <= 1'b0;
    end
  end

  assert_extra_single_R6: assert property (@(posedge clk) disable iff (!por_n)
    extra_rst |=> !extra_rst);
  assert_extra_blank_only_R6: assert property (@(posedge clk) disable iff (!por_n)
    extra_rst |-> (cond_q == ENTRY_BLANK_SUP || cond_q == ENTRY_BLANK_PLL));
  assert_cond_held_R9: assert property (@(posedge clk) disable iff (!por_n)
    sampled |=> $stable(cond_q));
endmodule

// File: rtl/mon_cop_ctrl.sv
module mon_cop_ctrl
  import mon_entry_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  entry_e     cond_q,
  input  logic [1:0] irq_lvl,
  input  logic       rst_hv,
  output logic       cop_dis
);
  logic hv_now;
  assign hv_now = (irq_lvl == IRQ_TV) || rst_hv;

  always_comb begin
    case (cond_q)
      ENTRY_BLANK_SUP,
      ENTRY_BLANK_PLL: cop_dis = 1'b1;
      ENTRY_HV:        cop_dis = hv_now;
      default:         cop_dis = 1'b0;
    endcase
  end

  assert_cop_blank_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cond_q == ENTRY_BLANK_SUP || cond_q == ENTRY_BLANK_PLL) |-> cop_dis);
  assert_cop_normal_R5: assert property (@(posedge clk) disable iff (!por_n)
    (cond_q == ENTRY_NONE) |-> !cop_dis);
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int PLL_MULT = 75,
  parameter int MULT_W   = $clog2(PLL_MULT + 1)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [VEC_W-1:0]  vec_hi,
  input  logic [VEC_W-1:0]  vec_lo,
  input  logic [1:0]        irq_lvl,
  input  logic              rst_hv,
  output logic              mon_mode,
  output logic [1:0]        entry_cond,
  output logic              pll_en,
  output logic [MULT_W-1:0] pll_mult,
  output logic              bus_clk_pll,
  output logic              extra_rst,
  output logic              portb_chk_en,
  output logic              cop_dis
);
  localparam logic [MULT_W-1:0] MULT_VAL = MULT_W'(PLL_MULT);

  entry_e cond_d, cond_q;
  logic   sampled;

  mon_entry_decode #(.VEC_W(VEC_W)) u_decode (
    .vec_hi (vec_hi),
    .vec_lo (vec_lo),
    .irq_lvl(irq_lvl),
    .cond   (cond_d)
  );

  mon_entry_latch u_latch (
    .clk      (clk),
    .por_n    (por_n),
    .cond_in  (cond_d),
    .cond_q   (cond_q),
    .sampled  (sampled),
    .extra_rst(extra_rst)
  );

  mon_cop_ctrl u_cop (
    .clk    (clk),
    .por_n  (por_n),
    .cond_q (cond_q),
    .irq_lvl(irq_lvl),
    .rst_hv (rst_hv),
    .cop_dis(cop_dis)
  );

  assign entry_cond   = cond_q;
  assign mon_mode     = (cond_q != ENTRY_NONE);
  assign pll_en       = (cond_q == ENTRY_BLANK_PLL);
  assign bus_clk_pll  = pll_en;
  assign pll_mult     = pll_en ? MULT_VAL : '0;
  assign portb_chk_en = (cond_q == ENTRY_HV);

  assert_pll_only_cond3_R4: assert property (@(posedge clk) disable iff (!por_n)
    pll_en |-> (mon_mode && !portb_chk_en));
  assert_portb_hv_only_R2: assert property (@(posedge clk) disable iff (!por_n)
    portb_chk_en |-> (mon_mode && !pll_en && !extra_rst));
  assert_idle_before_sample_R10: assert property (@(posedge clk) disable iff (!por_n)
    !sampled |-> (!mon_mode && !cop_dis && !extra_rst));
endmodule

// File: tb/mon_entry_ctrl_tb.sv
module mon_entry_ctrl_tb;
  logic       clk = 1'b0;
  logic       por_n;
  logic [7:0] vec_hi, vec_lo;
  logic [1:0] irq_lvl;
  logic       rst_hv;
  logic       mon_mode, pll_en, bus_clk_pll, extra_rst, portb_chk_en, cop_dis;
  logic [1:0] entry_cond;
  logic [6:0] pll_mult;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mon_entry_ctrl u_dut (
    .clk(clk), .por_n(por_n), .vec_hi(vec_hi), .vec_lo(vec_lo),
    .irq_lvl(irq_lvl), .rst_hv(rst_hv), .mon_mode(mon_mode),
    .entry_cond(entry_cond), .pll_en(pll_en), .pll_mult(pll_mult),
    .bus_clk_pll(bus_clk_pll), .extra_rst(extra_rst),
    .portb_chk_en(portb_chk_en), .cop_dis(cop_dis)
  );

  // {hi, lo, irq, rst_hv, mon, cond, pll, portb, cop, extra}
  localparam int NV = 9;
  localparam logic [25:0] VECS [NV] = '{
    {8'hFF, 8'hFF, 2'b00, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1}, // R4
    {8'hFF, 8'hFF, 2'b01, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1}, // R3
    {8'hFF, 8'hFF, 2'b11, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1}, // R3
    {8'hFF, 8'hFF, 2'b10, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
    {8'h12, 8'h34, 2'b10, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
    {8'hFF, 8'h00, 2'b00, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
    {8'h00, 8'hFF, 2'b01, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
    {8'hFE, 8'hFF, 2'b00, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
    {8'h12, 8'h34, 2'b11, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}  // R5
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Applies entry pins, releases reset, returns just after the sampling edge
  task automatic enter(input logic [7:0] h, input logic [7:0] l,
                       input logic [1:0] q, input logic r);
    @(negedge clk);
    por_n = 1'b0; vec_hi = h; vec_lo = l; irq_lvl = q; rst_hv = r;
    @(negedge clk);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; vec_hi = 8'hFF; vec_lo = 8'hFF; irq_lvl = 2'b00; rst_hv = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet while in reset
    chk("R10 mon", mon_mode, 0);
    chk("R10 cop", cop_dis, 0);
    chk("R10 extra", extra_rst, 0);
    chk("R10 pll", pll_en, 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VECS[i];
      enter(v[25:18], v[17:10], v[9:8], v[7]);
      chk("R1-5 mon", mon_mode, v[6]);
      chk("R1-5 cond", entry_cond, v[5:4]);
      chk("R4 pll", pll_en, v[3]);
      chk("R4 clk", bus_clk_pll, v[3]);
      chk("R11 mult", pll_mult, v[3] ? 75 : 0);
      chk("R2 portb", portb_chk_en, v[2]);
      chk("R7 cop", cop_dis, v[1]);
      chk("R6 extra", extra_rst, v[0]);
      @(negedge clk);
      chk("R6 extra drop", extra_rst, 0);
    end

    // R6 R7 R9: blank PLL entry, then inputs change
    enter(8'hFF, 8'hFF, 2'b00, 1'b0);
    chk("R6 pulse", extra_rst, 1);
    vec_hi = 8'h00; irq_lvl = 2'b10; rst_hv = 1'b1;
    @(negedge clk);
    chk("R9 cond held", entry_cond, 3);
    chk("R6 single", extra_rst, 0);
    irq_lvl = 2'b01; rst_hv = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 cop stays", cop_dis, 1);
    chk("R9 pll held", pll_en, 1);
    chk("R6 no repeat", extra_rst, 0);

    // R8: high-voltage handover from IRQ to RST
    enter(8'h55, 8'hAA, 2'b10, 1'b0);
    chk("R8 irq tv", cop_dis, 1);
    rst_hv = 1'b1;
    @(negedge clk);
    irq_lvl = 2'b01;
    @(negedge clk);
    chk("R8 rst tv", cop_dis, 1);
    chk("R9 still mon", mon_mode, 1);
    rst_hv = 1'b0;
    @(negedge clk);
    chk("R8 none", cop_dis, 0);
    irq_lvl = 2'b10;
    @(negedge clk);
    chk("R8 irq back", cop_dis, 1);

    // R9: normal entry is not upgraded by later pins
    enter(8'h12, 8'h34, 2'b00, 1'b0);
    vec_hi = 8'hFF; vec_lo = 8'hFF; irq_lvl = 2'b10;
    repeat (3) @(negedge clk);
    chk("R9 stays normal", mon_mode, 0);
    chk("R5 cop off", cop_dis, 0);

    // R10: reassert reset clears all
    por_n = 1'b0;
    @(negedge clk);
    chk("R10 reset cond", entry_cond, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule